// File: doc/BRIEF.md
# Link Training Sequencer

The sequencer runs the source side of serial display link training for one, two or four lanes. It has two phases. Clock recovery comes first and channel equalization follows. It does not move bytes on the sideband channel itself. It issues abstract read and write requests on a sink-register access port, and a separate sideband framer serves those requests. On the local side it drives the training pattern select and one common drive setting, which carries the swing and pre-emphasis levels.

In each phase the block waits a poll interval and reads a six-byte status block from the sink. It judges the per-lane status nibbles. If the phase has not yet passed, it merges the sink's per-lane adjustment requests into one common drive byte, writes that byte to the sink and tries again. A phase ends on success, on an iteration limit or on a failed status read. Afterwards the block waits, turns the sink pattern off, pulses a completion strobe to the source and reports its result.

Top module: `lt_sequencer`

## Requirements
- R1: On start the sink pattern register (access select 0) is written with 0, then with 1. If clock recovery passes it is written with 3 when `tps3_i` is high and with 2 otherwise. The last write is 0. `src_pattern_o` shows the pattern in use during each phase.
- R2: The first drive write (select 1) carries drive 0. Every drive write carries the current drive byte repeated into all four bytes of `acc_wdata_o`, and `drive_o` ends at the last drive applied.
- R3: After the first drive write the block waits 400 us and then one poll interval before the first status read (select 2). The poll interval is 100 us in clock recovery and 400 us in equalization when `rd_interval_i` is 0. Otherwise it is 4000 us times `rd_interval_i`. One microsecond is `US_CYCLES` clocks.
- R4: Lane n's status nibble sits in status byte n/2, at bit offset 4*(n mod 2). Clock recovery passes when bit 0 of the nibble is set for every active lane. Inactive lanes are ignored. `lanes_i` 0, 1 and 2 select 1, 2 and 4 active lanes.
- R5: A clock recovery round that does not pass aborts the phase as failed when the applied drive already has its maximum-swing flag set.
- R6: When the applied lane swing equals the swing applied in the previous round, a repeat counter increments. A different swing clears it. Clock recovery fails when the counter reaches 5.
- R7: Adjustment requests come from status bytes 4 and 5, one byte per lane pair. Each lane has a 2-bit swing followed by a 2-bit pre-emphasis, at bit offset 4*(n mod 2). The new drive takes the maximum of each field over the active lanes. It uses the layout swing [1:0], max-swing flag [2], pre-emphasis [4:3], max-emphasis flag [5]. Each flag is set when its level is 3.
- R8: Equalization passes when bit 0 of status byte 2 (alignment) is set and every active lane reports bits 2:0 all set.
- R9: Equalization fails at the read that follows its sixth adjustment, which makes 7 status reads in all.
- R10: A status read answered with `acc_err_i` fails the current phase whatever the data. A failed clock recovery skips equalization, and `eq_ok_o` is never set without `cr_ok_o`.
- R11: After the phases the block waits 400 us from the last status read, writes 0 to the sink pattern register, and pulses `src_done_o` for one cycle. It then holds `done_o`, `cr_ok_o` and `eq_ok_o` until the next start. `src_pattern_o` returns to 0.
- R12: After reset `done_o`, `cr_ok_o`, `eq_ok_o`, `acc_req_o`, `drive_o` and `src_pattern_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a training run (taken when idle) |
| lanes_i | input | 2 | Active lane code: 0=1, 1=2, 2=4 lanes |
| tps3_i | input | 1 | Sink supports pattern 3 for equalization |
| rd_interval_i | input | 8 | Sink read-interval code, 0 = short default |
| acc_req_o | output | 1 | Access request, held until acknowledged |
| acc_wr_o | output | 1 | 1 = write, 0 = read |
| acc_sel_o | output | 2 | Target: 0 pattern, 1 drive set, 2 status block |
| acc_wdata_o | output | 32 | Write data |
| acc_ack_i | input | 1 | Access completed this cycle |
| acc_err_i | input | 1 | Access failed, valid with ack |
| acc_rdata_i | input | 48 | Status block, bytes 0 to 5, valid with ack |
| src_pattern_o | output | 2 | Local training pattern select |
| drive_o | output | 8 | Common drive setting applied locally |
| src_done_o | output | 1 | One-cycle training-complete strobe to source |
| done_o | output | 1 | Run finished |
| cr_ok_o | output | 1 | Clock recovery passed |
| eq_ok_o | output | 1 | Equalization passed |

## Verification
With one clock per microsecond, the first clock-recovery status request appears exactly 400 plus the poll interval cycles after the edge that acknowledges the first drive write. The first equalization request appears one poll interval after the pattern write is acknowledged. The final pattern-off request appears 400 cycles after the last status read is acknowledged. A behavioural sink answers each request at the first falling edge after it is raised and stamps that edge. The bench subtracts these stamps and compares them with the exact figures. Counts of reads and drive writes, the pattern order and the final drive byte are compared with closed-form expectations once `done_o` is seen at a falling edge.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int LANES        = 4;
  localparam int STATUS_BYTES = 6;
  localparam int ALIGN_BYTE   = 2;
  localparam int ADJ_BYTE     = 4;

  localparam int HOLD_US      = 400;
  localparam int CR_POLL_US   = 100;
  localparam int EQ_POLL_US   = 400;
  localparam int IV_UNIT_US   = 4000;
  localparam int CR_REPEATS   = 5;
  localparam int EQ_ADJ_MAX   = 5;

  localparam logic [1:0] SEL_PATTERN = 2'd0;
  localparam logic [1:0] SEL_DRIVE   = 2'd1;
  localparam logic [1:0] SEL_STATUS  = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE_OFF, S_CR_PAT, S_CR_DRV, S_CR_HOLD, S_CR_POLL, S_CR_RD,
    S_CR_ADJ, S_EQ_PAT, S_EQ_POLL, S_EQ_RD, S_EQ_ADJ, S_FIN_HOLD, S_FIN_OFF,
    S_FIN_SRC
  } lt_state_e;
endpackage

// File: rtl/lt_lane_eval.sv
module lt_lane_eval
  import lt_pkg::*;
#(
  parameter int NL = LANES
) (
  input  logic [8*STATUS_BYTES-1:0] status_i,
  input  logic [NL-1:0]             active_i,
  output logic                      cr_all_o,
  output logic                      eq_all_o,
  output logic [7:0]                adj_drive_o
);
  logic [NL-1:0] cr_l, eq_l, nib_top;
  logic [1:0]    sw_l [NL];
  logic [1:0]    pr_l [NL];

  for (genvar l = 0; l < NL; l++) begin : g_lane
    localparam int NB = 8 * (l / 2) + 4 * (l % 2);
    localparam int AB = 8 * (ADJ_BYTE + l / 2) + 4 * (l % 2);
    logic [3:0] nib;
    assign nib        = status_i[NB +: 4];
    assign nib_top[l] = nib[3];
    assign cr_l[l]    = ~active_i[l] | nib[0];
    assign eq_l[l]    = ~active_i[l] | (&nib[2:0]);
    assign sw_l[l]    = active_i[l] ? status_i[AB +: 2] : 2'd0;
    assign pr_l[l]    = active_i[l] ? status_i[AB + 2 +: 2] : 2'd0;
  end

  logic align;
  assign align    = status_i[8 * ALIGN_BYTE];
  assign cr_all_o = &cr_l;
  assign eq_all_o = align & (&eq_l);

  logic [1:0] sw_max, pr_max;
  always_comb begin
    sw_max = '0;
    pr_max = '0;
    for (int l = 0; l < NL; l++) begin
      if (sw_l[l] > sw_max) sw_max = sw_l[l];
      if (pr_l[l] > pr_max) pr_max = pr_l[l];
    end
  end

  assign adj_drive_o = {2'b00, &pr_max, pr_max, &sw_max, sw_max};

  logic unused_bits;
  assign unused_bits = ^{nib_top, status_i[8*ALIGN_BYTE+1 +: 15]};
endmodule

// File: rtl/lt_timer.sv
module lt_timer #(
  parameter int US_CYCLES = 100,
  parameter int TW        = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] us_i,
  output logic          expire_o
);
  localparam logic [TW-1:0] US_C = TW'(US_CYCLES);

  logic [TW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= us_i * US_C - TW'(1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - TW'(1);
    end
  end

  assign expire_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/lt_sequencer.sv
module lt_sequencer
  import lt_pkg::*;
#(
  parameter int US_CYCLES = 100,
  parameter int TW        = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  lanes_i,
  input  logic        tps3_i,
  input  logic [7:0]  rd_interval_i,
  output logic        acc_req_o,
  output logic        acc_wr_o,
  output logic [1:0]  acc_sel_o,
  output logic [31:0] acc_wdata_o,
  input  logic        acc_ack_i,
  input  logic        acc_err_i,
  input  logic [47:0] acc_rdata_i,
  output logic [1:0]  src_pattern_o,
  output logic [7:0]  drive_o,
  output logic        src_done_o,
  output logic        done_o,
  output logic        cr_ok_o,
  output logic        eq_ok_o
);
  localparam logic [2:0] CR_LAST = 3'(CR_REPEATS - 1);
  localparam logic [2:0] EQ_LAST = 3'(EQ_ADJ_MAX);

  lt_state_e   state_q, state_d;
  logic [3:0]  act_q, act_d;
  logic        tps3_q, tps3_d;
  logic [7:0]  iv_q, iv_d;
  logic [7:0]  drive_q, drive_d;
  logic [1:0]  prev_sw_q, prev_sw_d;
  logic        sw_seen_q, sw_seen_d;
  logic [2:0]  att_q, att_d;
  logic [1:0]  pat_q, pat_d;
  logic        done_q, done_d, cr_ok_q, cr_ok_d, eq_ok_q, eq_ok_d;

  logic          tmr_go, tmr_exp;
  logic [TW-1:0] tmr_us, poll_cr, poll_eq;
  logic          cr_all, eq_all;
  logic [7:0]    adj_drive;

  lt_lane_eval #(.NL(LANES)) u_eval (
    .status_i   (acc_rdata_i),
    .active_i   (act_q),
    .cr_all_o   (cr_all),
    .eq_all_o   (eq_all),
    .adj_drive_o(adj_drive)
  );

  lt_timer #(.US_CYCLES(US_CYCLES), .TW(TW)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_go),
    .us_i    (tmr_us),
    .expire_o(tmr_exp)
  );

  assign poll_cr = (iv_q == '0) ? TW'(CR_POLL_US) : TW'(iv_q) * TW'(IV_UNIT_US);
  assign poll_eq = (iv_q == '0) ? TW'(EQ_POLL_US) : TW'(iv_q) * TW'(IV_UNIT_US);

  // access port decode
  always_comb begin
    acc_req_o   = 1'b1;
    acc_wr_o    = 1'b1;
    acc_sel_o   = SEL_PATTERN;
    acc_wdata_o = '0;
    unique case (state_q)
      S_PRE_OFF, S_FIN_OFF: acc_wdata_o = 32'd0;
      S_CR_PAT:             acc_wdata_o = 32'd1;
      S_EQ_PAT:             acc_wdata_o = tps3_q ? 32'd3 : 32'd2;
      S_CR_DRV, S_CR_ADJ, S_EQ_ADJ: begin
        acc_sel_o   = SEL_DRIVE;
        acc_wdata_o = {4{drive_q}};
      end
      S_CR_RD, S_EQ_RD: begin
        acc_wr_o  = 1'b0;
        acc_sel_o = SEL_STATUS;
      end
      default: begin
        acc_req_o = 1'b0;
        acc_wr_o  = 1'b0;
      end
    endcase
  end

  always_comb begin
    state_d   = state_q;
    act_d     = act_q;
    tps3_d    = tps3_q;
    iv_d      = iv_q;
    drive_d   = drive_q;
    prev_sw_d = prev_sw_q;
    sw_seen_d = sw_seen_q;
    att_d     = att_q;
    pat_d     = pat_q;
    done_d    = done_q;
    cr_ok_d   = cr_ok_q;
    eq_ok_d   = eq_ok_q;
    tmr_go    = 1'b0;
    tmr_us    = TW'(HOLD_US);
    unique case (state_q)
      S_IDLE: if (start_i) begin
        unique case (lanes_i)
          2'd0:    act_d = 4'b0001;
          2'd1:    act_d = 4'b0011;
          default: act_d = 4'b1111;
        endcase
        tps3_d    = tps3_i;
        iv_d      = rd_interval_i;
        drive_d   = '0;
        sw_seen_d = 1'b0;
        att_d     = '0;
        pat_d     = 2'd0;
        done_d    = 1'b0;
        cr_ok_d   = 1'b0;
        eq_ok_d   = 1'b0;
        state_d   = S_PRE_OFF;
      end
      S_PRE_OFF: if (acc_ack_i) begin
        pat_d   = 2'd1;
        state_d = S_CR_PAT;
      end
      S_CR_PAT: if (acc_ack_i) state_d = S_CR_DRV;
      S_CR_DRV: if (acc_ack_i) begin
        tmr_go  = 1'b1;
        state_d = S_CR_HOLD;
      end
      S_CR_HOLD: if (tmr_exp) begin
        tmr_go  = 1'b1;
        tmr_us  = poll_cr;
        state_d = S_CR_POLL;
      end
      S_CR_POLL: if (tmr_exp) state_d = S_CR_RD;
      S_CR_RD: if (acc_ack_i) begin
        if (acc_err_i) begin
          tmr_go  = 1'b1;
          state_d = S_FIN_HOLD;
        end else if (cr_all) begin
          cr_ok_d = 1'b1;
          pat_d   = tps3_q ? 2'd3 : 2'd2;
          att_d   = '0;
          state_d = S_EQ_PAT;
        end else if (drive_q[2]) begin
          tmr_go  = 1'b1;
          state_d = S_FIN_HOLD;
        end else if (sw_seen_q && drive_q[1:0] == prev_sw_q && att_q == CR_LAST) begin
          tmr_go  = 1'b1;
          state_d = S_FIN_HOLD;
        end else begin
          att_d     = (sw_seen_q && drive_q[1:0] == prev_sw_q) ? att_q + 3'd1 : 3'd0;
          prev_sw_d = drive_q[1:0];
          sw_seen_d = 1'b1;
          drive_d   = adj_drive;
          state_d   = S_CR_ADJ;
        end
      end
      S_CR_ADJ: if (acc_ack_i) begin
        tmr_go  = 1'b1;
        tmr_us  = poll_cr;
        state_d = S_CR_POLL;
      end
      S_EQ_PAT: if (acc_ack_i) begin
        tmr_go  = 1'b1;
        tmr_us  = poll_eq;
        state_d = S_EQ_POLL;
      end
      S_EQ_POLL: if (tmr_exp) state_d = S_EQ_RD;
      S_EQ_RD: if (acc_ack_i) begin
        if (!acc_err_i && eq_all) eq_ok_d = 1'b1;
        if (acc_err_i || eq_all || att_q > EQ_LAST) begin
          tmr_go  = 1'b1;
          state_d = S_FIN_HOLD;
        end else begin
          drive_d = adj_drive;
          state_d = S_EQ_ADJ;
        end
      end
      S_EQ_ADJ: if (acc_ack_i) begin
        att_d   = att_q + 3'd1;
        tmr_go  = 1'b1;
        tmr_us  = poll_eq;
        state_d = S_EQ_POLL;
      end
      S_FIN_HOLD: if (tmr_exp) begin
        pat_d   = 2'd0;
        state_d = S_FIN_OFF;
      end
      S_FIN_OFF: if (acc_ack_i) state_d = S_FIN_SRC;
      S_FIN_SRC: begin
        done_d  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      act_q     <= 4'b0001;
      tps3_q    <= 1'b0;
      iv_q      <= '0;
      drive_q   <= '0;
      prev_sw_q <= '0;
      sw_seen_q <= 1'b0;
      att_q     <= '0;
      pat_q     <= '0;
      done_q    <= 1'b0;
      cr_ok_q   <= 1'b0;
      eq_ok_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      act_q     <= act_d;
      tps3_q    <= tps3_d;
      iv_q      <= iv_d;
      drive_q   <= drive_d;
      prev_sw_q <= prev_sw_d;
      sw_seen_q <= sw_seen_d;
      att_q     <= att_d;
      pat_q     <= pat_d;
      done_q    <= done_d;
      cr_ok_q   <= cr_ok_d;
      eq_ok_q   <= eq_ok_d;
    end
  end

  assign src_pattern_o = pat_q;
  assign drive_o       = drive_q;
  assign src_done_o    = (state_q == S_FIN_SRC);
  assign done_o        = done_q;
  assign cr_ok_o       = cr_ok_q;
  assign eq_ok_o       = eq_ok_q;
endmodule

// File: rtl/lt_sequencer_chk.sv
module lt_sequencer_chk
  import lt_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [1:0]  lanes_i,
  input logic        tps3_i,
  input logic [7:0]  rd_interval_i,
  input logic        acc_req_o,
  input logic        acc_wr_o,
  input logic [1:0]  acc_sel_o,
  input logic [31:0] acc_wdata_o,
  input logic        acc_ack_i,
  input logic        acc_err_i,
  input logic [47:0] acc_rdata_i,
  input logic [1:0]  src_pattern_o,
  input logic [7:0]  drive_o,
  input logic        src_done_o,
  input logic        done_o,
  input logic        cr_ok_o,
  input logic        eq_ok_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_o && !acc_ack_i |=> acc_req_o && $stable(acc_sel_o) && $stable(acc_wr_o) && $stable(acc_wdata_o)); // R1
  AST_DRV_REPLICA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_o && acc_wr_o && acc_sel_o == SEL_DRIVE |-> acc_wdata_o == {4{drive_o}}); // R2
  AST_SWING_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o[2] |-> drive_o[1:0] == 2'd3); // R7
  AST_EMPH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o[5] |-> drive_o[4:3] == 2'd3); // R7
  AST_EQ_NEEDS_CR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_ok_o |-> cr_ok_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_done_o |=> !src_done_o && done_o && src_pattern_o == 2'd0); // R11
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !acc_req_o); // R11
endmodule

bind lt_sequencer lt_sequencer_chk u_chk (.*);

// File: tb/lt_sequencer_test.sv
module lt_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int US         = 1;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  lanes = 2'd0;
  logic        tps3 = 1'b0;
  logic [7:0]  iv = 8'd0;
  logic        acc_req, acc_wr, acc_ack = 1'b0, acc_err = 1'b0;
  logic [1:0]  acc_sel;
  logic [31:0] acc_wdata;
  logic [47:0] acc_rdata = '0;
  logic [1:0]  src_pat;
  logic [7:0]  drive;
  logic        src_done, done, cr_ok, eq_ok;

  lt_sequencer #(.US_CYCLES(US)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lanes_i(lanes), .tps3_i(tps3),
    .rd_interval_i(iv), .acc_req_o(acc_req), .acc_wr_o(acc_wr), .acc_sel_o(acc_sel),
    .acc_wdata_o(acc_wdata), .acc_ack_i(acc_ack), .acc_err_i(acc_err),
    .acc_rdata_i(acc_rdata), .src_pattern_o(src_pat), .drive_o(drive),
    .src_done_o(src_done), .done_o(done), .cr_ok_o(cr_ok), .eq_ok_o(eq_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;

  // scenario and sink records
  int sc_lanes, sc_crp, sc_eqp, sc_err;
  logic [7:0] sc_sw, sc_pr;
  int phase, n_rd, n_cr_rd, n_eq_rd, n_pat, n_drv, n_src_done;
  int pat_log [8];
  int first_drv, last_drv, src_pat_eq;
  int t_drv0_ack, t_cr_rd0, t_eq_pat_ack, t_eq_rd0, t_last_rd_ack, t_fin_req;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [47:0] build_status(input int ph, input int k);
    logic [47:0] s;
    int na;
    na = 1 << sc_lanes;
    s = '0;
    for (int l = 0; l < 4; l++) begin
      logic [3:0] nib;
      nib = 4'd0;
      if (l < na) begin
        if (ph == 1) nib = (k == sc_crp || l != na - 1) ? 4'b0001 : 4'b0000;
        else if (k == sc_eqp || k % 2 == 1 || l != 0) nib = 4'b0111;
        else nib = 4'b0011;
      end
      s[8*(l/2) + 4*(l%2) +: 4] = nib;
      s[8*(4 + l/2) + 4*(l%2) +: 2]     = sc_sw[2*l +: 2];
      s[8*(4 + l/2) + 4*(l%2) + 2 +: 2] = sc_pr[2*l +: 2];
    end
    if (ph != 1) s[16] = (k == sc_eqp) || (k % 2 == 0);
    return s;
  endfunction

  // behavioural sink: serves each request at the first falling edge it is seen
  initial begin
    forever begin
      @(negedge clk);
      if (src_done) n_src_done++;
      if (acc_ack) begin
        acc_ack = 1'b0;
        acc_err = 1'b0;
      end else if (acc_req && rst_n) begin
        if (acc_wr && acc_sel == 2'd0) begin
          pat_log[n_pat % 8] = int'(acc_wdata);
          n_pat++;
          phase = int'(acc_wdata);
          if (acc_wdata >= 2) t_eq_pat_ack = cyc + 1;
          if (acc_wdata == 0 && n_pat >= 3) t_fin_req = cyc;
        end else if (acc_wr && acc_sel == 2'd1) begin
          if (n_drv == 0) begin
            first_drv  = int'(acc_wdata);
            t_drv0_ack = cyc + 1;
          end
          last_drv = int'(acc_wdata);
          n_drv++;
        end else if (!acc_wr && acc_sel == 2'd2) begin
          n_rd++;
          if (phase == 1) begin
            n_cr_rd++;
            if (n_cr_rd == 1) t_cr_rd0 = cyc;
            acc_rdata = build_status(1, n_cr_rd);
          end else begin
            n_eq_rd++;
            if (n_eq_rd == 1) begin
              t_eq_rd0   = cyc;
              src_pat_eq = int'(src_pat);
            end
            acc_rdata = build_status(2, n_eq_rd);
          end
          if (n_rd == sc_err) begin
            acc_err   = 1'b1;
            acc_rdata = '1;
          end
          t_last_rd_ack = cyc + 1;
        end
        acc_ack = 1'b1;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > WD_CYCLES) begin
        tests++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_CYCLES);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  task automatic run(input string tag_cr, input string tag_eq, input int ln, input bit t3,
                     input int ivl, input int crp, input int eqp, input int err,
                     input logic [7:0] swv, input logic [7:0] prv);
    int na, smax, pmax, dexp, fail_at, cr_rd, eq_rd, e2, adj, fin, pc, pcr, peq;
    bit cok, eok;
    sc_lanes = ln; sc_crp = crp; sc_eqp = eqp; sc_err = err; sc_sw = swv; sc_pr = prv;
    phase = 0; n_rd = 0; n_cr_rd = 0; n_eq_rd = 0; n_pat = 0; n_drv = 0; n_src_done = 0;
    first_drv = -1; last_drv = -1; src_pat_eq = -1;
    t_drv0_ack = 0; t_cr_rd0 = 0; t_eq_pat_ack = 0; t_eq_rd0 = 0; t_last_rd_ack = 0; t_fin_req = 0;
    @(negedge clk);
    lanes = 2'(ln); tps3 = t3; iv = 8'(ivl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    // expectations from the requirements
    na = 1 << ln; smax = 0; pmax = 0;
    for (int l = 0; l < na; l++) begin
      if (int'(swv[2*l +: 2]) > smax) smax = int'(swv[2*l +: 2]);
      if (int'(prv[2*l +: 2]) > pmax) pmax = int'(prv[2*l +: 2]);
    end
    dexp = ((pmax == 3) ? 32 : 0) + pmax * 8 + ((smax == 3) ? 4 : 0) + smax;
    fail_at = (smax == 3) ? 2 : (smax == 0 ? 6 : 7);
    cok = (crp != 0 && crp <= fail_at);
    cr_rd = cok ? crp : fail_at;
    if (err != 0 && err <= cr_rd) begin cr_rd = err; cok = 1'b0; end
    eq_rd = 0; eok = 1'b0;
    if (cok) begin
      eok = (eqp != 0 && eqp <= 7);
      eq_rd = eok ? eqp : 7;
      e2 = err - cr_rd;
      if (err != 0 && e2 >= 1 && e2 <= eq_rd) begin eq_rd = e2; eok = 1'b0; end
    end
    adj = (cr_rd - 1) + (cok ? eq_rd - 1 : 0);
    fin = (adj > 0) ? dexp : 0;
    pc  = cok ? 4 : 3;
    pcr = (ivl == 0) ? 100 : 4000 * ivl;
    peq = (ivl == 0) ? 400 : 4000 * ivl;
    chk(tag_cr, "clock recovery reads", n_cr_rd, cr_rd);
    chk(tag_cr, "cr_ok", int'(cr_ok), int'(cok));
    chk(tag_eq, "equalization reads", n_eq_rd, eq_rd);
    chk(tag_eq, "eq_ok", int'(eq_ok), int'(eok));
    chk("R1", "pattern write count", n_pat, pc);
    chk("R1", "first pattern", pat_log[0], 0);
    chk("R1", "second pattern", pat_log[1], 1);
    if (cok) begin
      chk("R1", "eq pattern", pat_log[2], t3 ? 3 : 2);
      chk("R1", "source pattern in eq", src_pat_eq, t3 ? 3 : 2);
      chk("R3", "eq poll gap", t_eq_rd0 - t_eq_pat_ack, peq);
    end
    chk("R1", "last pattern", pat_log[(pc - 1) % 8], 0);
    chk("R2", "drive write count", n_drv, 1 + adj);
    chk("R2", "first drive data", first_drv, 0);
    chk("R2", "last drive data", last_drv, fin * 32'h01010101);
    chk("R7", "drive_o", int'(drive), fin);
    chk("R3", "first cr read gap", t_cr_rd0 - t_drv0_ack, 400 + pcr);
    chk("R11", "final hold gap", t_fin_req - t_last_rd_ack, 400);
    chk("R11", "src_done pulses", n_src_done, 1);
    chk("R11", "src_pattern at end", int'(src_pat), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "done after reset", int'(done), 0);
    chk("R12", "cr_ok after reset", int'(cr_ok), 0);
    chk("R12", "eq_ok after reset", int'(eq_ok), 0);
    chk("R12", "req after reset", int'(acc_req), 0);
    chk("R12", "drive after reset", int'(drive), 0);
    chk("R12", "pattern after reset", int'(src_pat), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // lane count x pattern-3 sweep; inactive lanes request the top levels
    for (int ln = 0; ln < 3; ln++)
      for (int t = 0; t < 2; t++)
        run("R4", "R8", ln, t[0], 0, 2, 2, 0, 8'b11_11_10_01, 8'b11_10_01_00);
    run("R4", "R8", 2, 1'b0, 0, 1, 1, 0, 8'b11_10_01_00, 8'b00_01_10_11);
    run("R6", "R8", 0, 1'b0, 0, 0, 1, 0, 8'b11_11_11_00, 8'b11_11_11_00);
    run("R6", "R8", 2, 1'b0, 0, 0, 1, 0, 8'b01_01_01_01, 8'b00_00_01_00);
    run("R5", "R8", 1, 1'b0, 0, 0, 1, 0, 8'b00_00_11_00, 8'b00_00_00_01);
    run("R4", "R9", 2, 1'b1, 0, 1, 0, 0, 8'b00_01_00_10, 8'b00_00_00_11);
    run("R10", "R10", 2, 1'b0, 0, 0, 0, 2, 8'b01_01_01_01, 8'b00_00_00_00);
    run("R4", "R10", 2, 1'b1, 0, 1, 0, 3, 8'b00_00_10_00, 8'b01_00_00_00);
    run("R7", "R8", 2, 1'b1, 0, 4, 5, 0, 8'b00_10_01_01, 8'b10_00_01_00);
    run("R3", "R8", 1, 1'b0, 1, 1, 1, 0, 8'b00_00_00_00, 8'b00_00_00_00);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule